// File: doc/BRIEF.md
# PS/2 Mouse Movement Packet Decoder

This block turns the raw two-wire serial stream from a PS/2 mouse into whole movement reports. It brings the mouse clock and data lines into the system clock domain and takes one data bit on each falling edge of the mouse clock. It collects 11-bit frames and checks each one. Every three good bytes form one report. The first byte is the status byte. The second byte is the X magnitude and the third is the Y magnitude.

Each finished report produces a one-cycle strobe. Along with the strobe come signed 9-bit X and Y deltas, the three button states and the two overflow flags. These values stay on the outputs until the next report. A frame that fails its checks produces a one-cycle error strobe and drops the report that was being built. A status byte whose always-one marker bit is clear is skipped, so that byte alignment can recover. A long quiet gap in the middle of a frame or a report also resets alignment.

Top module: `ps2_motion_decoder`

## Requirements
- R1: A frame has 11 bits taken on successive falling edges of the mouse clock: a 0 start bit, eight data bits least significant bit first, a parity bit that makes the nine data-plus-parity bits odd, and a 1 stop bit.
- R2: Three good bytes in a row, starting with an accepted status byte, produce exactly one `pkt_valid` pulse one clock wide, and no other `pkt_valid` pulse occurs.
- R3: `buttons[0]` is status bit 0 (left), `buttons[1]` is status bit 1 (right) and `buttons[2]` is status bit 2 (middle).
- R4: `dx` equals {status bit 4, second byte} and `dy` equals {status bit 5, third byte}, both as 9-bit two's complement values where 1 in the top bit means negative.
- R5: `x_ovf` equals status bit 6 and `y_ovf` equals status bit 7.
- R6: A byte received in the status position with bit 3 equal to 0 is dropped without an error, and the next byte is treated as a status candidate.
- R7: A frame with wrong parity gives a one-cycle `frame_err` pulse and drops the report in progress. The next good byte is treated as status.
- R8: A frame whose start bit is 1 or whose stop bit is 0 behaves as in R7.
- R9: When no falling mouse-clock edge arrives for `IDLE_CYCLES` clocks, a partly received frame and a partly built report are both dropped without an error.
- R10: While reset is high and right after it, `pkt_valid` and `frame_err` are 0, and `dx`, `dy`, `buttons`, `x_ovf` and `y_ovf` are 0.
- R11: The report outputs change only in the cycle in which `pkt_valid` is 1, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ps2_clk_in | input | 1 | Mouse clock line, asynchronous, idles at 1 |
| ps2_dat_in | input | 1 | Mouse data line, asynchronous, idles at 1 |
| pkt_valid | output | 1 | One-cycle strobe when a report is complete |
| dx | output | 9 | Signed X delta, positive means rightward |
| dy | output | 9 | Signed Y delta, positive means upward |
| buttons | output | 3 | Middle, right, left button states |
| x_ovf | output | 1 | X movement overflow flag |
| y_ovf | output | 1 | Y movement overflow flag |
| frame_err | output | 1 | One-cycle strobe on a parity, start or stop error |

## Verification
The bench builds the block with `IDLE_CYCLES` set to 300 and the default two synchronizer stages. At 20 system clocks per mouse bit, that value lets the bench hold a quiet gap longer than the limit in a few hundred cycles, both inside a frame and between the bytes of a report. A single frame still finishes well inside the window, so normal traffic never triggers the timeout. With the short window, recovery after a timeout, after a cleared marker bit and after each kind of frame error can all be reached within one short run.

// File: rtl/ps2m_pkg.sv
package ps2m_pkg;
  localparam int FRAME_BITS = 11;
  localparam int DELTA_W    = 9;

  // status byte bit positions
  localparam int ST_LEFT   = 0;
  localparam int ST_RIGHT  = 1;
  localparam int ST_MIDDLE = 2;
  localparam int ST_MARK   = 3;
  localparam int ST_XSIGN  = 4;
  localparam int ST_YSIGN  = 5;
  localparam int ST_XOVF   = 6;
  localparam int ST_YOVF   = 7;

  typedef logic [7:0] byte_t;

  typedef enum logic [1:0] {
    POS_STATUS = 2'd0,
    POS_X      = 2'd1,
    POS_Y      = 2'd2
  } byte_pos_e;
endpackage

// File: rtl/ps2m_sync.sv
module ps2m_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ps2_clk_in,
  input  logic ps2_dat_in,
  output logic clk_fall,
  output logic dat_s
);
  logic [STAGES-1:0] clk_sh;
  logic [STAGES-1:0] dat_sh;
  logic              clk_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sh   <= '1;
      dat_sh   <= '1;
      clk_last <= 1'b1;
    end else begin
      clk_sh   <= {clk_sh[STAGES-2:0], ps2_clk_in};
      dat_sh   <= {dat_sh[STAGES-2:0], ps2_dat_in};
      clk_last <= clk_sh[STAGES-1];
    end
  end

  assign clk_fall = clk_last & ~clk_sh[STAGES-1];
  assign dat_s    = dat_sh[STAGES-1];
endmodule

// File: rtl/ps2m_idle.sv
module ps2m_idle #(
  parameter int IDLE_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst,
  input  logic activity,
  output logic timeout
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES);

  logic [CW-1:0] quiet;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet   <= '0;
      timeout <= 1'b0;
    end else if (activity) begin
      quiet   <= '0;
      timeout <= 1'b0;
    end else begin
      timeout <= (quiet == LIMIT - 1'b1);
      if (quiet != LIMIT) quiet <= quiet + 1'b1;
    end
  end
endmodule

// File: rtl/ps2m_frame_rx.sv
module ps2m_frame_rx
  import ps2m_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_strobe,
  input  logic  bit_val,
  input  logic  flush,
  output logic  byte_ok,
  output logic  byte_bad,
  output byte_t byte_data
);
  localparam int BW = $clog2(FRAME_BITS);
  localparam logic [BW-1:0] LAST = BW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] shreg;
  logic [BW-1:0]         nbits;
  byte_t                 payload;
  logic                  good;

  // bits 0..9 sit in shreg[10:1] when the stop bit arrives
  assign payload = shreg[9:2];
  assign good    = (shreg[1] == 1'b0) && bit_val && (^{payload, shreg[10]});

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      nbits     <= '0;
      byte_ok   <= 1'b0;
      byte_bad  <= 1'b0;
      byte_data <= '0;
    end else begin
      byte_ok  <= 1'b0;
      byte_bad <= 1'b0;
      if (flush) begin
        nbits <= '0;
      end else if (bit_strobe) begin
        shreg <= {bit_val, shreg[FRAME_BITS-1:1]};
        if (nbits == LAST) begin
          nbits     <= '0;
          byte_ok   <= good;
          byte_bad  <= ~good;
          byte_data <= payload;
        end else begin
          nbits <= nbits + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ps2m_packer.sv
module ps2m_packer
  import ps2m_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               byte_ok,
  input  logic               byte_bad,
  input  byte_t              byte_data,
  input  logic               flush,
  output logic               pkt_valid,
  output logic [DELTA_W-1:0] dx,
  output logic [DELTA_W-1:0] dy,
  output logic [2:0]         buttons,
  output logic               x_ovf,
  output logic               y_ovf,
  output logic               frame_err
);
  byte_pos_e pos;
  byte_t     status_q;
  byte_t     xmag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= POS_STATUS;
      status_q  <= '0;
      xmag_q    <= '0;
      pkt_valid <= 1'b0;
      frame_err <= 1'b0;
      dx        <= '0;
      dy        <= '0;
      buttons   <= '0;
      x_ovf     <= 1'b0;
      y_ovf     <= 1'b0;
    end else begin
      pkt_valid <= 1'b0;
      frame_err <= 1'b0;
      if (byte_bad) begin
        frame_err <= 1'b1;
        pos       <= POS_STATUS;
      end else if (flush) begin
        pos <= POS_STATUS;
      end else if (byte_ok) begin
        unique case (pos)
          POS_STATUS: begin
            if (byte_data[ST_MARK]) begin
              status_q <= byte_data;
              pos      <= POS_X;
            end
          end
          POS_X: begin
            xmag_q <= byte_data;
            pos    <= POS_Y;
          end
          default: begin
            pkt_valid <= 1'b1;
            dx        <= {status_q[ST_XSIGN], xmag_q};
            dy        <= {status_q[ST_YSIGN], byte_data};
            buttons   <= {status_q[ST_MIDDLE], status_q[ST_RIGHT], status_q[ST_LEFT]};
            x_ovf     <= status_q[ST_XOVF];
            y_ovf     <= status_q[ST_YOVF];
            pos       <= POS_STATUS;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/ps2_motion_decoder.sv
module ps2_motion_decoder
  import ps2m_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_CYCLES = 200000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ps2_clk_in,
  input  logic               ps2_dat_in,
  output logic               pkt_valid,
  output logic [DELTA_W-1:0] dx,
  output logic [DELTA_W-1:0] dy,
  output logic [2:0]         buttons,
  output logic               x_ovf,
  output logic               y_ovf,
  output logic               frame_err
);
  logic  fall, dat_s, quiet_to;
  logic  b_ok, b_bad;
  byte_t b_data;

  ps2m_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
    .clk_fall(fall), .dat_s(dat_s)
  );

  ps2m_idle #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst(rst), .activity(fall), .timeout(quiet_to)
  );

  ps2m_frame_rx u_rx (
    .clk(clk), .rst(rst), .bit_strobe(fall), .bit_val(dat_s), .flush(quiet_to),
    .byte_ok(b_ok), .byte_bad(b_bad), .byte_data(b_data)
  );

  ps2m_packer u_pack (
    .clk(clk), .rst(rst), .byte_ok(b_ok), .byte_bad(b_bad), .byte_data(b_data),
    .flush(quiet_to), .pkt_valid(pkt_valid), .dx(dx), .dy(dy), .buttons(buttons),
    .x_ovf(x_ovf), .y_ovf(y_ovf), .frame_err(frame_err)
  );
endmodule

// File: rtl/ps2m_checker.sv
module ps2m_checker (
  input logic       clk,
  input logic       rst,
  input logic       pkt_valid,
  input logic       frame_err,
  input logic [8:0] dx,
  input logic [8:0] dy,
  input logic [2:0] buttons,
  input logic       x_ovf,
  input logic       y_ovf
);
  // R2: a report strobe lasts one cycle (three frames separate reports)
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> !pkt_valid);

  // R2: a completing byte can never also be a failing one
  a_r2_no_clash: assert property (@(posedge clk) disable iff (rst)
    !(pkt_valid && frame_err));

  // R7: error strobe is one cycle wide
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err);

  // R10: outputs cleared right after a reset cycle
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (!pkt_valid && !frame_err && dx == 9'd0 && dy == 9'd0 &&
             buttons == 3'd0 && !x_ovf && !y_ovf));

  // R11: report outputs hold between strobes
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!pkt_valid && !$past(rst)) |->
      ($stable(dx) && $stable(dy) && $stable(buttons) && $stable(x_ovf) && $stable(y_ovf)));
endmodule

bind ps2_motion_decoder ps2m_checker u_chk (
  .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .frame_err(frame_err),
  .dx(dx), .dy(dy), .buttons(buttons), .x_ovf(x_ovf), .y_ovf(y_ovf)
);

// File: tb/sim_ps2_motion_decoder.sv
`timescale 1ns/1ps
module sim_ps2_motion_decoder;
  localparam int IDLE = 300;
  localparam int HALF = 10;
  localparam int GAP  = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ps2c = 1'b1;
  logic ps2d = 1'b1;
  logic       pkt_valid, frame_err, x_ovf, y_ovf;
  logic [8:0] dx, dy;
  logic [2:0] buttons;

  always #2.5 clk = ~clk;

  ps2_motion_decoder #(.SYNC_STAGES(2), .IDLE_CYCLES(IDLE)) u0 (
    .clk(clk), .rst(rst), .ps2_clk_in(ps2c), .ps2_dat_in(ps2d),
    .pkt_valid(pkt_valid), .dx(dx), .dy(dy), .buttons(buttons),
    .x_ovf(x_ovf), .y_ovf(y_ovf), .frame_err(frame_err)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  // model state: packed {buttons[3], xovf, yovf, dx[9], dy[9]}
  logic [22:0] exp_q[$];
  int          err_pending = 0;
  logic [22:0] held = '0;
  int          m_pos = 0;
  logic [7:0]  m_status = '0;
  logic [7:0]  m_x = '0;

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic put_bit(input logic b);
    ps2d = b;
    tick(HALF);
    ps2c = 1'b0;
    tick(HALF);
    ps2c = 1'b1;
  endtask

  // kind: 0 good, 1 bad parity, 2 bad stop, 3 bad start
  task automatic send_frame(input logic [7:0] b, input int kind);
    logic par;
    par = ~(^b) ^ (kind == 1);
    put_bit(kind == 3);
    for (int i = 0; i < 8; i++) put_bit(b[i]);
    put_bit(par);
    ps2d = (kind == 2) ? 1'b0 : 1'b1;
    tick(HALF);
    ps2c = 1'b0;
    // model update at the stop-bit fall
    if (kind != 0) begin
      err_pending++;
      m_pos = 0;
    end else if (m_pos == 0) begin
      if (b[3]) begin m_status = b; m_pos = 1; end
    end else if (m_pos == 1) begin
      m_x = b; m_pos = 2;
    end else begin
      exp_q.push_back({m_status[2:0], m_status[6], m_status[7],
                       m_status[4], m_x, m_status[5], b});
      m_pos = 0;
    end
    tick(HALF);
    ps2c = 1'b1;
    ps2d = 1'b1;
    tick(GAP);
  endtask

  task automatic quiet_gap();
    tick(IDLE + 100);
    m_pos = 0;
  endtask

  task automatic drained(input string req);
    tick(20);
    check(exp_q.size() == 0 && err_pending == 0, req,
          32'(exp_q.size()), 32'(err_pending));
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (pkt_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected pkt_valid", 1, 0);
        end else begin
          held = exp_q.pop_front();
          check(buttons == held[22:20], "R3 buttons", 32'(buttons), 32'(held[22:20]));
          check(dx == held[17:9], "R4 dx", 32'(dx), 32'(held[17:9]));
          check(dy == held[8:0], "R4 dy", 32'(dy), 32'(held[8:0]));
          check({x_ovf, y_ovf} == held[19:18], "R5 overflow", 32'({x_ovf, y_ovf}), 32'(held[19:18]));
        end
      end else begin
        check({buttons, x_ovf, y_ovf, dx, dy} == held, "R11 hold",
              32'({buttons, x_ovf, y_ovf, dx, dy}), 32'(held));
      end
      if (frame_err) begin
        check(err_pending > 0, "R7 unexpected frame_err", 1, 0);
        if (err_pending > 0) err_pending--;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    tick(2);
    // R10 reset state
    check({pkt_valid, frame_err} == 2'b00, "R10 strobes in reset", 32'({pkt_valid, frame_err}), 0);
    check({buttons, x_ovf, y_ovf, dx, dy} == '0, "R10 outputs in reset",
          32'({buttons, x_ovf, y_ovf, dx, dy}), 0);
    tick(4);
    rst = 1'b0;
    tick(2);
    check({pkt_valid, frame_err} == 2'b00, "R10 strobes after reset", 32'({pkt_valid, frame_err}), 0);

    // R1 R2 R3 R4: left button, small positive motion
    send_frame(8'h09, 0); send_frame(8'h05, 0); send_frame(8'h10, 0);
    drained("R1 basic report");
    // R4 negative deltas, right button
    send_frame(8'h3A, 0); send_frame(8'hFB, 0); send_frame(8'h80, 0);
    drained("R4 negative report");
    // R5 overflow flags, middle button
    send_frame(8'hCC, 0); send_frame(8'hFF, 0); send_frame(8'h00, 0);
    drained("R5 overflow report");
    // R6 marker bit clear skipped, then realigned
    send_frame(8'h00, 0);
    send_frame(8'h0F, 0); send_frame(8'h01, 0); send_frame(8'h02, 0);
    drained("R6 realign");
    send_frame(8'h37, 0); send_frame(8'h08, 0);
    send_frame(8'h18, 0); send_frame(8'h7F, 0); send_frame(8'h81, 0);
    drained("R6 misaligned stream");
    // R7 parity error mid-report
    send_frame(8'h09, 0); send_frame(8'h22, 1);
    send_frame(8'h0A, 0); send_frame(8'h33, 0); send_frame(8'h44, 0);
    drained("R7 parity recovery");
    // R8 stop and start errors
    send_frame(8'h09, 0); send_frame(8'h11, 0); send_frame(8'h22, 2);
    send_frame(8'h29, 3);
    send_frame(8'h1C, 0); send_frame(8'h55, 0); send_frame(8'hAA, 0);
    drained("R8 framing recovery");
    // R9 quiet gap between bytes of a report
    send_frame(8'h09, 0); send_frame(8'h66, 0);
    quiet_gap();
    send_frame(8'h2B, 0); send_frame(8'h01, 0); send_frame(8'hFE, 0);
    drained("R9 report timeout");
    // R9 quiet gap inside a frame
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    quiet_gap();
    send_frame(8'h08, 0); send_frame(8'h00, 0); send_frame(8'h00, 0);
    drained("R9 frame timeout");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule